// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a synchronous requester and an asynchronous 16-bit pseudo-static RAM that has byte-lane control. The requester offers one word access at a time. Each access carries an address, write data, a two-bit byte enable and a read/write flag. The controller turns the accepted request into a timed sequence of chip-select, write-enable, output-enable and lane strobes. It samples the read word at the end of the access and hands it back with a one-cycle valid pulse. Bytes that were not enabled come back as zero.

Every memory timing figure is a parameter in nanoseconds, taken together with the clock period. Each figure is turned into a cycle count by rounding up, with a floor of one cycle. The memory is only selected when its active-low select is low and its active-high select is high. Outside an access, both selects and all strobes sit at their standby levels. A pseudo-static device refreshes itself, so no access may hold it selected longer than a parameterised ceiling. Access phases are clipped to that ceiling.

The request side is valid/ready with no buffering. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A requester that holds `req_valid` high during a busy period simply waits. Its fields are not looked at until the next idle cycle. The response has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must take when it comes.

Top module: `psram_ctrl`

## Requirements
- R1: After reset and whenever idle: `req_ready`=1, `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_ub_n`=`mem_lb_n`=1, `mem_dq_oe`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access and its recovery cycle are over. At default timing that is 7 cycles for a read and 8 for a write. Requests held during that time are not taken early.
- R3: A read selects the memory (`mem_cs1_n`=0, `mem_cs2`=1) with `mem_we_n`=1 and `mem_oe_n`=0. This lasts for the rounded-up maximum of read-cycle, address-access and output-enable-access times, which is 6 cycles at defaults. `mem_addr` holds the request address throughout.
- R4: During an access, `mem_lb_n` (bit 0 of `req_be`, data bits 7..0) and `mem_ub_n` (bit 1 of `req_be`, data bits 15..8) are low exactly for the enabled lanes.
- R5: A read returns its word on `rsp_rdata` with a one-cycle `rsp_valid` pulse. The pulse comes in the first cycle after the selection ends. Lanes not enabled read as zero.
- R6: A write holds `mem_we_n` low for the rounded-up maximum of the WE pulse width, the turn-off time plus data setup, and the write-cycle time. That is 6 cycles at defaults. `mem_oe_n` stays high during the whole write.
- R7: Write data is driven (`mem_dq_oe`=1) only after the rounded-up bus turn-off time has passed with `mem_we_n` low (2 cycles at defaults). It then stays driven for at least the data setup time before `mem_we_n` rises. The write is ended by `mem_we_n` rising one cycle before the selects and strobes go inactive, and data stays driven through that cycle.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low, and is low in every idle or recovery cycle.
- R9: Between two accesses there is at least one cycle with the memory deselected and every strobe inactive.
- R10: The memory is never selected for more than ceil(`T_MAX_ACT_NS`/`CLK_NS`) consecutive cycles. Read and write phases are shortened to fit.
- R11: Each nanosecond parameter becomes ceil(ns / `CLK_NS`) cycles, at least 1. For example, 35 ns at a 10 ns clock gives 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enable, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read word valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low high-byte strobe |
| mem_lb_n | output | 1 | Active-low low-byte strobe |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Two things can land in the same cycle. One is the read-response pulse in the recovery cycle. The other is a new request that the requester is already holding valid, waiting to be accepted. The bench provokes this by issuing reads and writes back to back, with `req_valid` never dropping between them. A scoreboard then judges that every response matches the shadow copy of the memory and arrives exactly one cycle after deselection. It also judges that the busy window lasts its full length, and that the pending request only starts after a clean standby cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_TURN,
    ST_WR_DATA,
    ST_WR_HOLD,
    ST_REC
  } pstate_e;

  typedef struct packed {
    logic sel;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  // Round a time up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Strobe levels that belong to each state.
  function automatic strobe_t decode(input pstate_e st);
    strobe_t s;
    s = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (st)
      ST_RD:      begin s.sel = 1'b1; s.oe_n = 1'b0; end
      ST_WR_TURN: begin s.sel = 1'b1; s.we_n = 1'b0; end
      ST_WR_DATA: begin s.sel = 1'b1; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WR_HOLD: begin s.sel = 1'b1; s.dq_oe = 1'b1; end
      default:    ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R11: a phase loaded with a non-zero count cannot finish in its first cycle
  p_no_early_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !done);
endmodule

// File: rtl/psram_lanes.sv
module psram_lanes #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [LANES-1:0]  be,
  input  logic              lanes_on,
  input  logic [DATA_W-1:0] raw,
  output logic [LANES-1:0]  strb_n,
  output logic [DATA_W-1:0] masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_n[g]         = !(lanes_on && be[g]);
    assign masked[g*8 +: 8]  = be[g] ? raw[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 10,
  parameter int T_RC_NS      = 55,
  parameter int T_AA_NS      = 55,
  parameter int T_OE_NS      = 25,
  parameter int T_WC_NS      = 55,
  parameter int T_PWE_NS     = 45,
  parameter int T_SD_NS      = 25,
  parameter int T_HZWE_NS    = 20,
  parameter int T_MAX_ACT_NS = 15000000,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int LANES    = DATA_W / 8;
  localparam int ACT_MAX  = ns2cyc(T_MAX_ACT_NS, CLK_NS);
  localparam int RD_NEED  = imax(ns2cyc(T_RC_NS, CLK_NS),
                                 imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int RD_LEN   = imin(RD_NEED, ACT_MAX);
  localparam int HZ_CYC   = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int SD_CYC   = ns2cyc(T_SD_NS, CLK_NS);
  localparam int WE_NEED  = imax(ns2cyc(T_PWE_NS, CLK_NS),
                                 imax(HZ_CYC + SD_CYC, ns2cyc(T_WC_NS, CLK_NS)));
  localparam int WR_AVAIL = imax(ACT_MAX - 1, 2);
  localparam int TURN_LEN = imin(HZ_CYC, WR_AVAIL - 1);
  localparam int DATA_LEN = imax(imin(WE_NEED - TURN_LEN, WR_AVAIL - TURN_LEN), 1);
  localparam int SAT_MAX  = ACT_MAX + 1;

  pstate_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [1:0]          be_q;
  logic                accept, load, done;
  logic [CNT_W-1:0]    load_val;
  logic [LANES-1:0]    be_d;
  logic [LANES-1:0]    strb_n;
  logic [DATA_W-1:0]   masked;
  strobe_t             dec_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (req_valid) st_d = req_write ? ST_WR_TURN : ST_RD;
      ST_RD:      if (done) st_d = ST_REC;
      ST_WR_TURN: if (done) st_d = ST_WR_DATA;
      ST_WR_DATA: if (done) st_d = ST_WR_HOLD;
      ST_WR_HOLD: st_d = ST_REC;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign load = (st_d != st_q);

  always_comb begin
    case (st_d)
      ST_RD:      load_val = CNT_W'(RD_LEN - 1);
      ST_WR_TURN: load_val = CNT_W'(TURN_LEN - 1);
      ST_WR_DATA: load_val = CNT_W'(DATA_LEN - 1);
      default:    load_val = '0;
    endcase
  end

  psram_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  assign be_d  = accept ? req_be : be_q;
  assign dec_d = decode(st_d);

  psram_lanes #(.DATA_W(DATA_W)) i_lanes (
    .be       (be_d),
    .lanes_on (dec_d.sel),
    .raw      (mem_dq_in),
    .strb_n   (strb_n),
    .masked   (masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  // Registered strobes: each pin changes from a flop, never from decode logic.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
    end else begin
      mem_cs1_n <= !dec_d.sel;
      mem_cs2   <= dec_d.sel;
      mem_we_n  <= dec_d.we_n;
      mem_oe_n  <= dec_d.oe_n;
      mem_dq_oe <= dec_d.dq_oe;
      mem_lb_n  <= strb_n[0];
      mem_ub_n  <= strb_n[LANES-1];
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st_q == ST_RD) && done;
      if ((st_q == ST_RD) && done) rsp_rdata <= masked;
    end
  end

  // Consecutive selected cycles, saturating, for the active-time ceiling check.
  logic [31:0] act_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       act_cnt <= '0;
    else if (!mem_cs1_n) begin
      if (act_cnt < 32'(SAT_MAX))     act_cnt <= act_cnt + 1'b1;
    end else                          act_cnt <= '0;
  end

  p_max_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= 32'(ACT_MAX));

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2 && mem_ub_n && mem_lb_n && !mem_dq_oe));

  p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_oe_off_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_we_ends_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs1_n && mem_dq_oe));

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_recover_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs1_n) |=> mem_cs1_n);
endmodule

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- instance A: default timing ----------------
  logic        a_valid = 1'b0, a_write = 1'b0;
  logic [18:0] a_addr_i = '0;
  logic [15:0] a_wdata = '0;
  logic [1:0]  a_be = '0;
  logic        a_ready, a_rsp_valid;
  logic [15:0] a_rdata;
  logic [18:0] a_maddr;
  logic        a_cs1_n, a_cs2, a_we_n, a_oe_n, a_ub_n, a_lb_n, a_dq_oe;
  logic [15:0] a_dq_out, a_dq_in;

  psram_ctrl i_psram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(a_valid), .req_ready(a_ready), .req_write(a_write),
    .req_addr(a_addr_i), .req_wdata(a_wdata), .req_be(a_be),
    .rsp_valid(a_rsp_valid), .rsp_rdata(a_rdata),
    .mem_addr(a_maddr), .mem_cs1_n(a_cs1_n), .mem_cs2(a_cs2),
    .mem_we_n(a_we_n), .mem_oe_n(a_oe_n), .mem_ub_n(a_ub_n), .mem_lb_n(a_lb_n),
    .mem_dq_out(a_dq_out), .mem_dq_oe(a_dq_oe), .mem_dq_in(a_dq_in)
  );

  // ---------------- instance B: 35 ns active ceiling ----------------
  logic        b_valid = 1'b0, b_write = 1'b0;
  logic [1:0]  b_be = 2'b11;
  logic        b_ready, b_rsp_valid;
  logic [15:0] b_rdata;
  logic [18:0] b_maddr;
  logic        b_cs1_n, b_cs2, b_we_n, b_oe_n, b_ub_n, b_lb_n, b_dq_oe;
  logic [15:0] b_dq_out;

  psram_ctrl #(.T_MAX_ACT_NS(35)) i_psram_ctrl_b (
    .clk(clk), .rst_n(rst_n),
    .req_valid(b_valid), .req_ready(b_ready), .req_write(b_write),
    .req_addr(19'h00011), .req_wdata(16'hC0DE), .req_be(b_be),
    .rsp_valid(b_rsp_valid), .rsp_rdata(b_rdata),
    .mem_addr(b_maddr), .mem_cs1_n(b_cs1_n), .mem_cs2(b_cs2),
    .mem_we_n(b_we_n), .mem_oe_n(b_oe_n), .mem_ub_n(b_ub_n), .mem_lb_n(b_lb_n),
    .mem_dq_out(b_dq_out), .mem_dq_oe(b_dq_oe), .mem_dq_in(16'h1234)
  );

  // ---------------- memory model and shadow ----------------
  logic [15:0] model  [64];
  logic [15:0] shadow [64];
  logic sel_a;
  logic prev_we_a = 1'b1;
  assign sel_a = !a_cs1_n && a_cs2;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 257) ^ 16'h3C5A;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      model[i]  = init_word(i);
      shadow[i] = init_word(i);
    end
  end

  always_comb begin
    a_dq_in = 16'hFFFF;
    if (sel_a && !a_oe_n && a_we_n) begin
      a_dq_in = 16'hEEEE;
      if (!a_lb_n) a_dq_in[7:0]  = model[a_maddr[5:0]][7:0];
      if (!a_ub_n) a_dq_in[15:8] = model[a_maddr[5:0]][15:8];
    end
  end

  always @(negedge clk) begin
    if (prev_we_a == 1'b0 && a_we_n == 1'b1 && sel_a && a_dq_oe) begin
      if (!a_lb_n) model[a_maddr[5:0]][7:0]  = a_dq_out[7:0];
      if (!a_ub_n) model[a_maddr[5:0]][15:8] = a_dq_out[15:8];
    end
    prev_we_a = a_we_n;
  end

  // ---------------- scoreboard queues ----------------
  typedef struct {
    bit          wr;
    logic [18:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
  } acc_t;
  acc_t        acc_q[$];
  logic [15:0] exp_q[$];

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // Driver: offers a request and waits at the ports until it is taken.
  task automatic do_req(input bit wr, input logic [18:0] addr,
                        input logic [15:0] data, input logic [1:0] be);
    acc_t a;
    a_valid = 1'b1; a_write = wr; a_addr_i = addr; a_wdata = data; a_be = be;
    while (!a_ready) @(negedge clk);
    a.wr = wr; a.addr = addr; a.data = data; a.be = be;
    acc_q.push_back(a);
    if (wr) shadow[addr[5:0]] = (shadow[addr[5:0]] & ~lane_mask(be)) | (data & lane_mask(be));
    else    exp_q.push_back(shadow[addr[5:0]] & lane_mask(be));
    @(posedge clk);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  // ---------------- monitor A ----------------
  int   run = 0, we_lo = 0, turn = 0, dlo = 0, hold = 0, oe_lo = 0;
  int   gap = 10, busy = 0;
  bit   bad_addr, bad_lane, bad_drive, gap_clean = 1'b1;
  bit   prev_sel = 1'b0, prev_rsp = 1'b0, last_wr = 1'b0;
  acc_t cur;

  always @(negedge clk) begin
    if (mon_on) begin
      if (sel_a) begin
        if (!prev_sel) begin
          chk(gap >= 1 && gap_clean, "R9", "standby cycle before access", gap, 1);
          if (acc_q.size() == 0) chk(1'b0, "R2", "access with no accepted request", 0, 1);
          else cur = acc_q[0];
          run = 0; we_lo = 0; turn = 0; dlo = 0; hold = 0; oe_lo = 0;
          bad_addr = 1'b0; bad_lane = 1'b0; bad_drive = 1'b0;
        end
        run++;
        if (a_maddr != cur.addr) bad_addr = 1'b1;
        if ({a_ub_n, a_lb_n} != ~cur.be) bad_lane = 1'b1;
        if (a_dq_oe && !a_oe_n) bad_drive = 1'b1;
        if (!a_we_n) begin
          we_lo++;
          if (a_dq_oe) dlo++;
          else begin turn++; if (dlo != 0) bad_drive = 1'b1; end
        end else if (a_dq_oe) hold++;
        if (!a_oe_n) oe_lo++;
      end else begin
        if (prev_sel) begin
          if (cur.wr) begin
            chk(we_lo == 6, "R6", "WE low cycles", we_lo, 6);
            chk(oe_lo == 0, "R6", "OE low during write", oe_lo, 0);
            chk(turn == 2, "R7", "turnaround cycles before data", turn, 2);
            chk(dlo >= 3 && dlo == 4, "R7", "data setup cycles", dlo, 4);
            chk(hold == 1 && run == 7, "R7", "hold cycle after WE rise", hold, 1);
          end else begin
            chk(run == 6 && oe_lo == 6, "R3", "read select/OE cycles", run, 6);
            chk(we_lo == 0, "R3", "WE low in read", we_lo, 0);
          end
          chk(!bad_addr, "R3", "address stable in access", int'(a_maddr), int'(cur.addr));
          chk(!bad_lane, "R4", "lane strobes vs enable", 0, int'(cur.be));
          chk(!bad_drive, "R8", "bus drive while OE low or early", 1, 0);
          void'(acc_q.pop_front());
          last_wr   = cur.wr;
          gap       = 0;
          gap_clean = 1'b1;
        end
        gap++;
        if (!a_we_n || !a_oe_n || !a_ub_n || !a_lb_n || a_dq_oe) gap_clean = 1'b0;
      end
      if (a_rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected response", int'(a_rdata), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(a_rdata == e, "R5", "read word", int'(a_rdata), int'(e));
          chk(prev_sel && !sel_a && !prev_rsp, "R5", "pulse right after deselect", 0, 1);
        end
      end
      if (!a_ready) busy++;
      else begin
        if (busy > 0) chk(busy == (last_wr ? 8 : 7), "R2", "busy window", busy, last_wr ? 8 : 7);
        busy = 0;
      end
      prev_sel = sel_a;
      prev_rsp = a_rsp_valid;
    end
  end

  // ---------------- monitor B ----------------
  int run_b = 0;
  int rsp_b = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (!b_cs1_n && b_cs2) run_b++;
      else begin
        if (run_b > 0) chk(run_b == 4, "R10", "selected cycles under 35 ns ceiling (R11 rounding)", run_b, 4);
        run_b = 0;
      end
      if (b_rsp_valid) begin
        rsp_b++;
        chk(b_rdata == 16'h1234, "R10", "clipped read word", int'(b_rdata), 16'h1234);
      end
    end
  end

  task automatic do_req_b(input bit wr);
    b_valid = 1'b1; b_write = wr;
    while (!b_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle levels after reset
    chk(a_ready == 1'b1, "R1", "ready after reset", int'(a_ready), 1);
    chk(a_cs1_n && !a_cs2, "R1", "selects in standby", int'({a_cs1_n, a_cs2}), 2);
    chk(a_we_n && a_oe_n, "R1", "WE/OE inactive", int'({a_we_n, a_oe_n}), 3);
    chk(a_ub_n && a_lb_n && !a_dq_oe, "R1", "lanes off, bus released",
        int'({a_ub_n, a_lb_n, a_dq_oe}), 6);
    mon_on = 1'b1;

    // Directed: full word, single lanes, masked reads (R3 R4 R5 R6 R7)
    do_req(1'b1, 19'h00005, 16'hBEEF, 2'b11);
    do_req(1'b0, 19'h00005, 16'h0000, 2'b11);
    do_req(1'b1, 19'h40005, 16'h1177, 2'b01);
    do_req(1'b1, 19'h7FFC9, 16'hAB00, 2'b10);
    do_req(1'b0, 19'h40005, 16'h0000, 2'b01);
    do_req(1'b0, 19'h7FFC9, 16'h0000, 2'b10);
    do_req(1'b0, 19'h00009, 16'h0000, 2'b11);
    do_req(1'b0, 19'h00003, 16'h0000, 2'b11);
    // Back-to-back mixed pattern, valid never dropped (R2 R9)
    for (int k = 0; k < 12; k++) begin
      do_req((k % 3) != 2, 19'(k * 4099 + 1), 16'(k * 16'h1357 + 16'h0F0F), 2'((k % 3) + 1));
      do_req(1'b0, 19'(k * 4099 + 1), 16'h0000, 2'b11);
    end
    while (acc_q.size() != 0 || exp_q.size() != 0 || !a_ready) @(negedge clk);
    repeat (3) @(negedge clk);

    // R10: active ceiling clips read and write phases
    do_req_b(1'b0);
    do_req_b(1'b1);
    do_req_b(1'b0);
    while (!b_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rsp_b == 2, "R10", "responses from clipped instance", rsp_b, 2);
    chk(a_ready && a_cs1_n && !a_dq_oe, "R1", "idle at end", int'({a_ready, a_cs1_n, a_dq_oe}), 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule